// File: doc/BRIEF.md
# CMI Line Encoder

This block turns a serial NRZ bit stream into Code Mark Inversion symbols so that an optical line transmitter can be driven directly. Each data bit becomes two half-bit symbols on one unipolar output. A zero always goes out as a low half followed by a high half. A one goes out as a flat level for the whole bit. Each one takes the level opposite to the one before it, so long runs of ones still carry transitions. Any substitution coding such as HDB3 or B8ZS is applied upstream. The encoder takes the bits exactly as they arrive.

The block runs on a clock at twice the bit rate. A one-cycle strobe marks each new input bit, and strobes are at least two cycles apart. A per-bit enable chooses CMI coding or plain NRZ pass-through. In pass-through the bit value is held for both halves, and the alternation state does not move. The enable is sampled together with the data bit, so it may change between any two bits.

Top module: `cmi_line_encoder`

## Requirements
- R1: While reset is low, and afterwards until the first coded symbol reaches the output, `line_out` is 0. The alternation state starts so that the first CMI one after reset is sent high.
- R2: A bit sampled with `cmi_en`=1 and `nrz_in`=1 is sent as one level held for both halves. That level is the inverse of the level used for the previous CMI one.
- R3: Consecutive CMI ones, counted across any zeros between them, alternate high, low, high, and so on.
- R4: A bit sampled with `cmi_en`=1 and `nrz_in`=0 is sent as 0 in the first half and 1 in the second half.
- R5: CMI zeros leave the alternation state unchanged.
- R6: A bit sampled with `cmi_en`=0 is sent as the value of `nrz_in` in both halves.
- R7: Bits sent with `cmi_en`=0 leave the alternation state unchanged, whatever their value.
- R8: For a strobe seen at clock edge E, `line_out` carries the first half after edge E+2 and the second half after edge E+3. This is a latency of one bit period.
- R9: When no new bit has been strobed, `line_out` holds the last half-symbol it sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a new input bit |
| nrz_in | input | 1 | NRZ data bit, sampled with `bit_stb` |
| cmi_en | input | 1 | 1 selects CMI coding, 0 selects NRZ pass-through, sampled with `bit_stb` |
| line_out | output | 1 | Unipolar line symbol stream, one half-bit per clock |

## Verification
The assertions assume that `bit_stb` is never high on two consecutive clocks. This spacing keeps the two halves of one bit from overlapping the next bit in the serializer. The assertions also assume that `nrz_in` and `cmi_en` are valid at every strobed edge. The stimulus raises the strobe on every other clock and drives both data inputs on the falling edge. It therefore never strobes back to back, and the symbol stream stays continuous. The one directed test that stops strobing checks the hold behaviour without breaking the spacing rule.

// File: rtl/cmi_pkg.sv
// Package: shared types and the symbol mapping function of the CMI encoder.
// Assumes: a symbol is always two half-bit levels, sent first then second.
package cmi_pkg;

    // One captured input bit with its coding selection.
    typedef struct packed {
        logic code_en;
        logic data;
    } cmi_bit_t;

    // Two half-bit line levels for one input bit.
    typedef struct packed {
        logic first;
        logic second;
    } cmi_sym_t;

    // Maps one bit to its pair of half-symbols, given the last mark level.
    function automatic cmi_sym_t cmi_map(input cmi_bit_t b, input logic last_mark);
        cmi_sym_t s;
        if (!b.code_en) begin
            s.first  = b.data;
            s.second = b.data;
        end else if (b.data) begin
            s.first  = ~last_mark;
            s.second = ~last_mark;
        end else begin
            s.first  = 1'b0;
            s.second = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/cmi_bit_capture.sv
// Module: registers the NRZ bit and the coding enable on each bit strobe.
// Assumes: bit_stb is a single-cycle pulse, at least two cycles apart.
module cmi_bit_capture
    import cmi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_stb,
    input  logic     nrz_in,
    input  logic     cmi_en,
    output logic     cap_vld,
    output cmi_bit_t cap_bit
);

    // Captures the bit and its enable, and pulses valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_bit <= '0;
        end else begin
            cap_vld <= bit_stb;
            if (bit_stb) begin
                cap_bit.data    <= nrz_in;
                cap_bit.code_en <= cmi_en;
            end
        end
    end

endmodule

// File: rtl/cmi_symbol_map.sv
// Module: turns a captured bit into a two-half symbol and keeps the mark
// alternation state.
// Assumes: in_vld arrives no more often than every second cycle.
module cmi_symbol_map
    import cmi_pkg::*;
#(
    parameter logic MARK_RESET = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_vld,
    input  cmi_bit_t in_bit,
    output logic     sym_vld,
    output cmi_sym_t sym,
    output logic     mark_level
);

    logic mark_q;

    // Encodes the bit and flips the mark level only on a coded one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_vld <= 1'b0;
            sym     <= '0;
            mark_q  <= MARK_RESET;
        end else begin
            sym_vld <= in_vld;
            if (in_vld) begin
                sym <= cmi_map(in_bit, mark_q);
                if (in_bit.code_en && in_bit.data) begin
                    mark_q <= ~mark_q;
                end
            end
        end
    end

    assign mark_level = mark_q;

endmodule

// File: rtl/cmi_serializer.sv
// Module: sends a two-half symbol on the line, one half per clock, and holds
// the last level when idle.
// Assumes: a new symbol never arrives while the second half is pending.
module cmi_serializer
    import cmi_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sym_vld,
    input  cmi_sym_t sym,
    output logic     line_out
);

    logic line_q;
    logic pend_q;
    logic second_q;

    // Sends the first half on load, then the stored second half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= IDLE_LEVEL;
            pend_q   <= 1'b0;
            second_q <= 1'b0;
        end else if (sym_vld) begin
            line_q   <= sym.first;
            second_q <= sym.second;
            pend_q   <= 1'b1;
        end else if (pend_q) begin
            line_q <= second_q;
            pend_q <= 1'b0;
        end
    end

    assign line_out = line_q;

endmodule

// File: rtl/cmi_line_encoder.sv
// Module: top level of the CMI line encoder: capture, symbol map, serializer.
// Assumes: clk runs at twice the bit rate and bit_stb pulses once per bit.
module cmi_line_encoder
    import cmi_pkg::*;
#(
    parameter logic MARK_RESET = 1'b0,
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic nrz_in,
    input  logic cmi_en,
    output logic line_out
);

    logic     cap_vld;
    cmi_bit_t cap_bit;
    logic     sym_vld;
    cmi_sym_t sym;
    logic     mark_level;

    cmi_bit_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .nrz_in  (nrz_in),
        .cmi_en  (cmi_en),
        .cap_vld (cap_vld),
        .cap_bit (cap_bit)
    );

    cmi_symbol_map #(.MARK_RESET(MARK_RESET)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (cap_vld),
        .in_bit     (cap_bit),
        .sym_vld    (sym_vld),
        .sym        (sym),
        .mark_level (mark_level)
    );

    cmi_serializer #(.IDLE_LEVEL(IDLE_LEVEL)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_vld  (sym_vld),
        .sym      (sym),
        .line_out (line_out)
    );

endmodule

// File: rtl/cmi_line_encoder_chk.sv
// Module: property checker for the CMI line encoder, attached with bind.
// Assumes: sampled inputs come from the encoder's own ports and state.
module cmi_line_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic nrz_in,
    input logic cmi_en,
    input logic line_out,
    input logic cap_vld,
    input logic mark_level
);

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !line_out); // R1

    AST_ONE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && cmi_en && nrz_in) |-> ##4 $stable(line_out)); // R2

    AST_ZERO_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && cmi_en && !nrz_in) |-> ##3 !line_out ##1 line_out); // R4

    AST_PLAIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !cmi_en) |-> ##3 (line_out == $past(nrz_in, 3))
                                 ##1 (line_out == $past(nrz_in, 4))); // R6

    AST_MARK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && cmi_en && nrz_in) |-> ##2 (mark_level != $past(mark_level))); // R3

    AST_MARK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !(cmi_en && nrz_in)) |-> ##2 $stable(mark_level)); // R5

    AST_CAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> cap_vld); // R8

endmodule

bind cmi_line_encoder cmi_line_encoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .nrz_in     (nrz_in),
    .cmi_en     (cmi_en),
    .line_out   (line_out),
    .cap_vld    (cap_vld),
    .mark_level (mark_level)
);

// File: tb/tb_cmi_line_encoder.sv
// Bench: runs a vector table of bits through the encoder, then directed
// tests for reset, latency and idle hold.
module tb_cmi_line_encoder;

    logic clk;
    logic rst_n;
    logic bit_stb;
    logic nrz_in;
    logic cmi_en;
    logic line_out;

    int checks;
    int errors;
    bit done;

    cmi_line_encoder dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .nrz_in   (nrz_in),
        .cmi_en   (cmi_en),
        .line_out (line_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Vector bits: {cmi_en, nrz_in, expected first half, expected second half}
    localparam int NVEC = 16;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1111,  // R1 R2: first one after reset is high
        4'b1001,  // R4: zero low then high
        4'b1100,  // R3: next one low
        4'b1111,  // R3: next one high
        4'b1001,  // R4
        4'b1001,  // R5: zeros keep state
        4'b1100,  // R5: one after zeros still alternates
        4'b0111,  // R6: plain one
        4'b0000,  // R6: plain zero
        4'b0111,  // R6
        4'b1111,  // R7: plain bits did not move state
        4'b1001,
        4'b0000,  // R7
        4'b1100,
        4'b1001,
        4'b1111
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: line_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        bit_stb = 1'b0;
        nrz_in  = 1'b0;
        cmi_en  = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1", line_out, 1'b0);

        // Table walk: iteration j strobes bit j and checks bit j-1.
        for (int j = 0; j <= NVEC; j++) begin
            if (j < NVEC) begin
                bit_stb = 1'b1;
                cmi_en  = VEC[j][3];
                nrz_in  = VEC[j][2];
            end else begin
                bit_stb = 1'b0;
            end
            tick();
            if (j >= 1) check("R2/R3/R4/R6 first", line_out, VEC[j-1][1]);
            bit_stb = 1'b0;
            tick();
            if (j >= 1) check("R2/R3/R4/R6 second", line_out, VEC[j-1][0]);
        end

        // R9: idle hold of the last half-symbol (last entry ended high).
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R9", line_out, 1'b1);
        end

        // R1 and R8: reset, then a single coded one with exact latency.
        do_reset();
        check("R1", line_out, 1'b0);
        bit_stb = 1'b1;
        cmi_en  = 1'b1;
        nrz_in  = 1'b1;
        tick();                         // after edge E
        bit_stb = 1'b0;
        nrz_in  = 1'b0;
        check("R8 not early E", line_out, 1'b0);
        tick();                         // after E+1
        check("R8 not early E+1", line_out, 1'b0);
        tick();                         // after E+2
        check("R8 first half", line_out, 1'b1);
        tick();                         // after E+3
        check("R8 second half", line_out, 1'b1);

        // R7: plain ones after reset, then a coded one must still go high.
        do_reset();
        for (int k = 0; k < 3; k++) begin
            bit_stb = 1'b1;
            cmi_en  = 1'b0;
            nrz_in  = 1'b1;
            tick();
            bit_stb = 1'b0;
            tick();
        end
        bit_stb = 1'b1;
        cmi_en  = 1'b1;
        nrz_in  = 1'b1;
        tick();
        bit_stb = 1'b0;
        tick();
        tick();                          // first half of the coded one
        check("R7", line_out, 1'b1);
        tick();
        check("R7", line_out, 1'b1);

        // R9: no strobes after the last bit: level holds.
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R9", line_out, 1'b1);
        end

        done = 1'b1;
    end

    // Watchdog and the single summary line.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule